// File: doc/BRIEF.md
# Fixed-Point Butterfly Multiply-Shift Unit

This block carries out one radix-2 butterfly step on signed fixed-point integers. It takes a 32-bit instruction word and three XLEN-bit operand values: `a`, `b` and a coefficient `c`. It forms `a + b` and `a - b`. It multiplies each of these by `c`, keeping the low XLEN bits of each product. It then scales each product down with a rounding arithmetic right shift. The instruction word gives the shift amount. The two results come out together, paired with the two destination register indices taken from the same word.

The surrounding pipeline reads the register file itself and presents the operand values together with the instruction word. The block accepts one item on every cycle where `in_valid` and `in_ready` are both high. Each result pair appears a fixed number of cycles later, marked by `out_valid`. The output path has no backpressure, so the block can take one item per cycle for as long as the caller supplies them.

Top module: `bfly_unit`

## Requirements
- R1: `sum = a + b` and `diff = a - b` are formed at XLEN bits, and any overflow wraps with no saturation.
- R2: Each of sum and diff is multiplied by `c` as a signed value, and only the low XLEN bits of the product are kept, wrapping silently.
- R3: For a shift amount sh in 1..31, 2^(sh-1) is added to the kept product (wrapping at XLEN bits), and the total is then shifted right arithmetically by sh, so the top sh bits copy its sign bit.
- R4: For sh = 0, the kept product is returned unchanged, with no rounding term.
- R5: `out_res1` is the scaled result of the sum leg and `out_res2` is the scaled result of the difference leg.
- R6: The shift amount is `in_insn[10:6]` and the first destination index is `in_insn[25:21]` (bit 0 = least significant). `out_rd1` equals that index and `out_rd2` equals that index plus one, modulo 32. All other instruction bits (opcode, both source fields, extended opcode, record bit) have no effect on any output.
- R7: An item accepted at a rising edge produces exactly one `out_valid` pulse, visible after the LAT-th rising edge counting the acceptance edge as the first (LAT = 2 + OUT_DELAY). Items accepted on consecutive cycles come out on consecutive cycles and in order.
- R8: While `rst` is high, `in_ready` and `out_valid` are low. `in_ready` rises after the first rising edge with `rst` low and then stays high.
- R9: With XLEN = 64, a = 0x0A70, b = 0xE6B8, c = 0x2D41 and sh = 14, the results are `out_res1 = 0x000000000000AA85` and `out_res2 = 0xFFFFFFFFFFFF643E`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can accept an item |
| in_insn | input | 32 | Instruction word carrying the destination and shift fields |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| in_c | input | XLEN | Signed coefficient |
| out_valid | output | 1 | Result pair present |
| out_rd1 | output | 5 | Destination index for the sum-leg result |
| out_rd2 | output | 5 | Destination index for the difference-leg result |
| out_res1 | output | XLEN | Scaled sum-leg result |
| out_res2 | output | XLEN | Scaled difference-leg result |

## Verification
With the default `OUT_DELAY = 0`, a result pair is due two rising edges after its item is presented: the acceptance edge loads the sum and difference register, and the next edge loads the scaled results. The driver drives at the falling edge and stamps each expected item with the cycle count at which it is due. The monitor checks, at each falling edge where `out_valid` is high, that the oldest item's due cycle equals the current count. A result that arrives early, late, twice or never is therefore caught, as well as a wrong value.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
   // Instruction word field positions, bit 0 = least significant.
   localparam int unsigned INSN_W     = 32;
   localparam int unsigned REG_IDX_W  = 5;
   localparam int unsigned SHAMT_W    = 5;
   localparam int unsigned DST_LSB    = 21;
   localparam int unsigned SHAMT_LSB  = 6;

   typedef logic [REG_IDX_W-1:0] reg_idx_t;

   typedef struct packed {
      reg_idx_t             dst_lo;
      reg_idx_t             dst_hi;
      logic [SHAMT_W-1:0]   shamt;
   } bfly_fields_t;
endpackage

// File: rtl/bfly_decode.sv
module bfly_decode
   import bfly_pkg::*;
#(
   parameter int unsigned SHW = 5
) (
   input  logic [INSN_W-1:0] insn,
   output bfly_fields_t      fields
);
   generate
      if (SHW != SHAMT_W) begin : g_bad_shw
         $error("bfly_decode: SHW must match the instruction shift field width");
      end
   endgenerate

   logic unused_fields;
   assign unused_fields = ^{insn[31:26], insn[20:11], insn[5:0]};

   always_comb begin
      fields.dst_lo = insn[DST_LSB +: REG_IDX_W];
      fields.dst_hi = fields.dst_lo + reg_idx_t'(1);
      fields.shamt  = insn[SHAMT_LSB +: SHAMT_W];
   end
endmodule

// File: rtl/bfly_scale.sv
module bfly_scale #(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned SHW      = 5,
   parameter bit          ROUND_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic [XLEN-1:0] x,
   input  logic [XLEN-1:0] coef,
   input  logic [SHW-1:0]  sh,
   output logic [XLEN-1:0] res_q
);
   generate
      if (XLEN < (1 << SHW)) begin : g_bad_width
         $error("bfly_scale: XLEN must cover every shift amount");
      end
   endgenerate

   logic [XLEN-1:0] prod;
   logic [XLEN-1:0] bias;
   logic [XLEN-1:0] biased;
   logic [XLEN-1:0] shifted;

   // Low XLEN bits of a signed product equal those of the unsigned one.
   assign prod = x * coef;

   generate
      if (ROUND_EN) begin : g_round
         always_comb begin
            bias = '0;
            if (sh != '0) bias[sh - 1'b1] = 1'b1;
         end
      end else begin : g_trunc
         assign bias = '0;
      end
   endgenerate

   assign biased  = prod + bias;
   assign shifted = $signed(biased) >>> sh;

   always_ff @(posedge clk) begin
      if (en) res_q <= shifted;
   end

   AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (rst)
      (en && sh == '0) |=> res_q == $past(prod));                            // R4
   AST_SIGN_COPIED: assert property (@(posedge clk) disable iff (rst)
      en |=> res_q[XLEN-1] == $past(biased[XLEN-1]));                        // R3
endmodule

// File: rtl/bfly_unit.sv
module bfly_unit
   import bfly_pkg::*;
#(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned SHW       = 5,
   parameter int unsigned OUT_DELAY = 0,
   parameter bit          ROUND_EN  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [INSN_W-1:0]    in_insn,
   input  logic [XLEN-1:0]      in_a,
   input  logic [XLEN-1:0]      in_b,
   input  logic [XLEN-1:0]      in_c,
   output logic                 out_valid,
   output logic [REG_IDX_W-1:0] out_rd1,
   output logic [REG_IDX_W-1:0] out_rd2,
   output logic [XLEN-1:0]      out_res1,
   output logic [XLEN-1:0]      out_res2
);
   localparam int unsigned LAT  = 2 + OUT_DELAY;
   localparam int unsigned PKTW = 1 + 2 * REG_IDX_W + 2 * XLEN;

   generate
      if (XLEN < 2 * (1 << SHW)) begin : g_bad_xlen
         $error("bfly_unit: XLEN too narrow for the shift field");
      end
      if (LAT > 64) begin : g_bad_delay
         $error("bfly_unit: OUT_DELAY out of range");
      end
   endgenerate

   logic         rdy_q;
   logic         in_fire;
   bfly_fields_t dec;

   assign in_ready = rdy_q;
   assign in_fire  = in_valid & rdy_q;

   always_ff @(posedge clk) begin
      if (rst) rdy_q <= 1'b0;
      else     rdy_q <= 1'b1;
   end

   bfly_decode #(.SHW(SHW)) u_decode (
      .insn   (in_insn),
      .fields (dec)
   );

   // Stage A: sum / difference legs and the decoded fields
   logic            vld_a;
   logic [XLEN-1:0] leg_a [2];
   logic [XLEN-1:0] coef_a;
   logic [SHW-1:0]  sh_a;
   reg_idx_t        rd1_a, rd2_a;

   always_ff @(posedge clk) begin
      if (rst) vld_a <= 1'b0;
      else     vld_a <= in_fire;
   end

   always_ff @(posedge clk) begin
      if (in_fire) begin
         leg_a[0] <= in_a + in_b;
         leg_a[1] <= in_a - in_b;
         coef_a   <= in_c;
         sh_a     <= dec.shamt;
         rd1_a    <= dec.dst_lo;
         rd2_a    <= dec.dst_hi;
      end
   end

   // Stage B: multiply, round and shift, one instance per leg
   logic            vld_b;
   logic [XLEN-1:0] leg_b [2];
   reg_idx_t        rd1_b, rd2_b;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_leg
         bfly_scale #(.XLEN(XLEN), .SHW(SHW), .ROUND_EN(ROUND_EN)) u_scale (
            .clk   (clk),
            .rst   (rst),
            .en    (vld_a),
            .x     (leg_a[g]),
            .coef  (coef_a),
            .sh    (sh_a),
            .res_q (leg_b[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) vld_b <= 1'b0;
      else     vld_b <= vld_a;
   end

   always_ff @(posedge clk) begin
      if (vld_a) begin
         rd1_b <= rd1_a;
         rd2_b <= rd2_a;
      end
   end

   // Optional output retiming stages
   logic [PKTW-1:0] pkt_b;
   logic [PKTW-1:0] pkt_out;
   assign pkt_b = {vld_b, rd1_b, rd2_b, leg_b[0], leg_b[1]};

   generate
      if (OUT_DELAY == 0) begin : g_direct
         assign pkt_out = pkt_b;
      end else begin : g_retime
         logic [PKTW-1:0] pipe_q [OUT_DELAY];
         for (genvar s = 0; s < OUT_DELAY; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst) pipe_q[s] <= '0;
               else if (s == 0) pipe_q[s] <= pkt_b;
               else pipe_q[s] <= pipe_q[s-1];
            end
         end
         assign pkt_out = pipe_q[OUT_DELAY-1];
      end
   endgenerate

   assign {out_valid, out_rd1, out_rd2, out_res1, out_res2} = pkt_out;

   AST_LEG_PARITY: assert property (@(posedge clk) disable iff (rst)
      vld_a |-> leg_a[0][0] == leg_a[1][0]);                                 // R1
   AST_DEST_ADJACENT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_rd2 == reg_idx_t'(out_rd1 + 1'b1));                  // R6
   AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !$isunknown({out_res1, out_res2, out_rd1, out_rd2}));    // R7
   AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
      in_ready |=> in_ready);                                                // R8
endmodule

// File: tb/test_bfly_unit.sv
module test_bfly_unit;
   localparam int CLK_P = 10;
   localparam int XLEN  = 64;
   localparam int LAT   = 2;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [31:0]     in_insn = '0;
   logic [XLEN-1:0] in_a = '0, in_b = '0, in_c = '0;
   logic            out_valid;
   logic [4:0]      out_rd1, out_rd2;
   logic [XLEN-1:0] out_res1, out_res2;

   always #(CLK_P/2) clk = ~clk;

   bfly_unit i_bfly_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_insn(in_insn), .in_a(in_a), .in_b(in_b), .in_c(in_c),
      .out_valid(out_valid), .out_rd1(out_rd1), .out_rd2(out_rd2),
      .out_res1(out_res1), .out_res2(out_res2)
   );

   typedef struct {
      logic [63:0] r1;
      logic [63:0] r2;
      logic [4:0]  d1;
      logic [4:0]  d2;
      int          due;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string rq, logic [63:0] act, logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual 0x%h expected 0x%h", rq, act, expv);
      end
   endtask

   // Independent reference: signed 64-bit arithmetic, round half up.
   function automatic longint ref_leg(longint x, longint c, int sh);
      longint p;
      p = x * c;
      if (sh > 0) p = p + (longint'(1) <<< (sh - 1));
      return p >>> sh;
   endfunction

   function automatic logic [31:0] mk_insn(logic [4:0] rt, logic [4:0] sh, logic [31:0] junk);
      logic [31:0] w;
      w = junk;
      w[25:21] = rt;
      w[10:6]  = sh;
      return w;
   endfunction

   task automatic send(logic [4:0] rt, logic [4:0] sh, logic [31:0] junk,
                       logic [63:0] a, logic [63:0] b, logic [63:0] c, string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      in_insn  = mk_insn(rt, sh, junk);
      in_a = a; in_b = b; in_c = c;
      e.r1  = ref_leg(longint'(a + b), longint'(c), int'(sh));
      e.r2  = ref_leg(longint'(a - b), longint'(c), int'(sh));
      e.d1  = rt;
      e.d2  = rt + 5'd1;
      e.due = cyc + LAT;
      e.tag = tag;
      if (in_ready) exp_q.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_insn  = $urandom();
         in_a = {$urandom(), $urandom()};
      end
   endtask

   // Monitor: pop the oldest expected pair whenever a result appears.
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R7 unexpected result", 64'(out_valid), 64'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " R5 sum leg"},  out_res1, e.r1);
            check({e.tag, " R5 diff leg"}, out_res2, e.r2);
            check("R6 first destination", 64'(out_rd1), 64'(e.d1));
            check("R6 second destination", 64'(out_rd2), 64'(e.d2));
            check("R7 arrival cycle", 64'(cyc), 64'(e.due));
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_P * 50000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R7 watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      // R8: reset state
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R8 in_ready in reset", 64'(in_ready), 64'd0);
         check("R8 out_valid in reset", 64'(out_valid), 64'd0);
      end
      rst = 1'b0;
      @(negedge clk);
      check("R8 in_ready after reset", 64'(in_ready), 64'd1);
      check("R8 out_valid after reset", 64'(out_valid), 64'd0);

      // R9: reference vector, destinations 1 and 2
      send(5'd1, 5'd14, 32'h0, 64'h0A70, 64'hE6B8, 64'h2D41, "R9");
      idle(3);
      check("R9 queue drained", 64'(exp_q.size()), 64'd0);

      // R4: zero shift passes the product through
      send(5'd4, 5'd0, 32'hFFFF_FFFF, 64'd1234567, 64'd89, 64'hFFFF_FFFF_FFFF_FFFD, "R4");
      send(5'd9, 5'd0, $urandom(), {$urandom(), $urandom()}, {$urandom(), $urandom()},
           {$urandom(), $urandom()}, "R4");
      // R3: largest shift, rounding on half and sign fill
      send(5'd7, 5'd31, 32'h0, 64'h4000_0000, 64'h0, 64'h1, "R3");
      send(5'd7, 5'd31, 32'h0, 64'hFFFF_FFFF_C000_0000, 64'h0, 64'h1, "R3");
      send(5'd8, 5'd1, 32'h0, 64'h3, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
      // R1 / R2: wrapping sum, difference and product at the extremes
      send(5'd31, 5'd5, 32'h0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
           64'h8000_0000_0000_0000, "R1");
      send(5'd30, 5'd3, 32'h0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
           64'h7FFF_FFFF_FFFF_FFFF, "R2");
      send(5'd0, 5'd17, 32'h0, 64'h8000_0000_0000_0000, 64'h1,
           64'h8000_0000_0000_0000, "R2");
      idle(4);

      // R6: unrelated instruction bits flipped, same item twice
      send(5'd12, 5'd9, 32'h0, 64'h1111_2222, 64'h0333_4444, 64'h5555, "R6");
      send(5'd12, 5'd9, 32'hFC1F_F83F, 64'h1111_2222, 64'h0333_4444, 64'h5555, "R6");
      idle(3);

      // R7: random traffic with bubbles, then a back-to-back burst
      for (int k = 0; k < 200; k++) begin
         send($urandom(), $urandom(), $urandom(), {$urandom(), $urandom()},
              {$urandom(), $urandom()}, {$urandom(), $urandom()}, "R7");
         if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
      end
      for (int k = 0; k < 40; k++) begin
         send($urandom(), $urandom_range(0, 31), $urandom(), {$urandom(), $urandom()},
              {$urandom(), $urandom()}, {16'h0, $urandom_range(0, 65535)}, "R7");
      end
      idle(LAT + 4);
      check("R7 every accepted item returned", 64'(exp_q.size()), 64'd0);
      done = 1'b1;
      finish_run();
   end
endmodule